// File: doc/BRIEF.md
# Aliased-Index General Register Bank

This block is the integer register bank of a 64-bit execution core. It keeps 31 general registers plus one stack pointer, serves two reads and one write per cycle, and accepts a separate link write that records a return address. Each access carries its own size flag, 64-bit or 32-bit, and a context flag. The context flag decides what the top index (31) means. In zero context the top index is a constant zero that ignores writes. In stack context it is a real stack pointer register.

Read data is registered, so a read index presented in one cycle gives its data after the next rising edge. A read that targets the register being written in the same cycle sees the new value. This also holds for the zero-extended value of a 32-bit write and for the return address of a link write. The program counter lives elsewhere. The link path takes the counter of the branch and stores that value plus 4.

Top module: `gpr_bank_alias`

## Requirements
- R1: Indices 0 to 30 select 31 independent 64-bit registers. A full-width read returns the value last written to that index. The data appears one clock edge after the index is presented.
- R2: A read of index 31 with the context flag low (zero context) returns 0.
- R3: A write to index 31 with the context flag low changes no register and does not change the stack pointer.
- R4: With the context flag high (stack context), index 31 reads and writes a dedicated stack pointer. That register is separate from registers 0 to 30.
- R5: A write with the narrow flag high stores bits 31:0 of the write data and clears bits 63:32 of the destination.
- R6: A read with the narrow flag high returns bits 31:0 of the selected register, with bits 63:32 equal to 0.
- R7: A link write stores the supplied branch address plus 4 into register 30.
- R8: When a link write and a normal write both target register 30 in one cycle, register 30 takes the normal write data.
- R9: A read of the register written in the same cycle returns the new value. This covers the zero-extended value of a narrow write and the link address.
- R10: A synchronous active-high reset clears all 31 registers, the stack pointer and both read outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Normal write enable |
| wr_idx | input | 5 | Write destination index |
| wr_data | input | 64 | Write data |
| wr_narrow | input | 1 | 1 = 32-bit write with zero extension |
| wr_sp_ctx | input | 1 | 1 = index 31 is the stack pointer, 0 = index 31 is zero |
| lnk_en | input | 1 | Link write enable |
| lnk_pc | input | 64 | Address of the branch; register 30 receives this plus 4 |
| rda_idx | input | 5 | Read port A index |
| rda_narrow | input | 1 | Read port A 32-bit flag |
| rda_sp_ctx | input | 1 | Read port A context flag |
| rdb_idx | input | 5 | Read port B index |
| rdb_narrow | input | 1 | Read port B 32-bit flag |
| rdb_sp_ctx | input | 1 | Read port B context flag |
| rda_data | output | 64 | Read port A data, registered |
| rdb_data | output | 64 | Read port B data, registered |

## Verification
The bench targets the top index under both contexts.

- A design that decodes the zero context wrongly would return the stack pointer instead of 0, or would let a discarded write change the stack pointer.
- Same-cycle reads of a register under write expose a missing bypass, which shows up as stale data one cycle late. A narrow write read back in the same cycle at full width exposes a bypass that forwards the unextended data.
- Colliding link and normal writes to register 30 catch a reversed priority.
- A long random run with mixed sizes and contexts, compared every cycle against a behavioural model, catches crossed ports or indices.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int unsigned DEF_XLEN   = 64;
  localparam int unsigned DEF_NARROW = 32;
  localparam int unsigned DEF_NREG   = 31;
  localparam int unsigned DEF_STEP   = 4;

  typedef enum logic {
    CTX_ZERO  = 1'b0,
    CTX_STACK = 1'b1
  } idx_ctx_e;
endpackage

// File: rtl/gpr_write_ctrl.sv
module gpr_write_ctrl #(
  parameter int unsigned XLEN      = 64,
  parameter int unsigned NARROW    = 32,
  parameter int unsigned NREG      = 31,
  parameter int unsigned LINK_STEP = 4,
  localparam int unsigned IDX_W    = $clog2(NREG + 1),
  localparam int unsigned LINK_IDX = NREG - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [XLEN-1:0]  wr_data,
  input  logic             wr_narrow,
  input  logic             wr_sp_ctx,
  input  logic             lnk_en,
  input  logic [XLEN-1:0]  lnk_pc,
  output logic             norm_we,
  output logic [IDX_W-1:0] norm_idx,
  output logic [XLEN-1:0]  norm_val,
  output logic             lnk_we,
  output logic [XLEN-1:0]  lnk_val,
  output logic             sp_we,
  output logic [XLEN-1:0]  sp_val
);
  import gpr_pkg::*;

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NREG);
  localparam logic [IDX_W-1:0] LNK_IDX = IDX_W'(LINK_IDX);

  logic            to_top;
  logic [XLEN-1:0] sized;

  always_comb begin
    sized = wr_narrow ? {{(XLEN-NARROW){1'b0}}, wr_data[NARROW-1:0]} : wr_data;
  end

  assign to_top   = (wr_idx == TOP_IDX);
  assign norm_we  = wr_en && (wr_idx < TOP_IDX);
  assign norm_idx = wr_idx;
  assign norm_val = sized;
  assign sp_we    = wr_en && to_top && (idx_ctx_e'(wr_sp_ctx) == CTX_STACK);
  assign sp_val   = sized;
  // the normal write owns register 30 when both paths aim at it
  assign lnk_we   = lnk_en && !(norm_we && (wr_idx == LNK_IDX));
  assign lnk_val  = lnk_pc + XLEN'(LINK_STEP);

  // R3: a zero-context write to the top index reaches no storage
  p_zero_sink_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && to_top && !wr_sp_ctx) |-> (!sp_we && !norm_we));

  // R8: a colliding link write is suppressed
  p_link_yields_r8: assert property (@(posedge clk) disable iff (rst)
    (lnk_en && wr_en && wr_idx == LNK_IDX) |-> (!lnk_we && norm_we));
endmodule

// File: rtl/gpr_storage.sv
module gpr_storage #(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned NREG   = 31,
  localparam int unsigned IDX_W = $clog2(NREG + 1),
  localparam int unsigned LINK_IDX = NREG - 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      norm_we,
  input  logic [IDX_W-1:0]          norm_idx,
  input  logic [XLEN-1:0]           norm_val,
  input  logic                      lnk_we,
  input  logic [XLEN-1:0]           lnk_val,
  input  logic                      sp_we,
  input  logic [XLEN-1:0]           sp_val,
  output logic [NREG-1:0][XLEN-1:0] regs_q,
  output logic [XLEN-1:0]           sp_q
);
  genvar g;
  generate
    for (g = 0; g < NREG; g++) begin : g_reg
      logic hit;
      assign hit = norm_we && (norm_idx == IDX_W'(g));
      if (g == LINK_IDX) begin : g_link
        always_ff @(posedge clk) begin
          if (rst)         regs_q[g] <= '0;
          else if (hit)    regs_q[g] <= norm_val;
          else if (lnk_we) regs_q[g] <= lnk_val;
        end
      end else begin : g_plain
        always_ff @(posedge clk) begin
          if (rst)      regs_q[g] <= '0;
          else if (hit) regs_q[g] <= norm_val;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)        sp_q <= '0;
    else if (sp_we) sp_q <= sp_val;
  end

  // R10: reset leaves the stack pointer and register 0 cleared
  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (sp_q == '0 && regs_q[0] == '0));

  // R4: the stack pointer holds when no stack-context write arrives
  p_sp_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !sp_we |=> $stable(sp_q));
endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port #(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned NARROW = 32,
  parameter int unsigned NREG   = 31,
  localparam int unsigned IDX_W = $clog2(NREG + 1),
  localparam int unsigned LINK_IDX = NREG - 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [IDX_W-1:0]          rd_idx,
  input  logic                      rd_narrow,
  input  logic                      rd_sp_ctx,
  input  logic [NREG-1:0][XLEN-1:0] regs_q,
  input  logic [XLEN-1:0]           sp_q,
  input  logic                      norm_we,
  input  logic [IDX_W-1:0]          norm_idx,
  input  logic [XLEN-1:0]           norm_val,
  input  logic                      lnk_we,
  input  logic [XLEN-1:0]           lnk_val,
  input  logic                      sp_we,
  input  logic [XLEN-1:0]           sp_val,
  output logic [XLEN-1:0]           rd_q
);
  import gpr_pkg::*;

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(NREG);
  localparam logic [IDX_W-1:0] LNK_IDX = IDX_W'(LINK_IDX);

  logic [XLEN-1:0] stored, fresh, shaped;

  always_comb begin
    stored = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_idx == IDX_W'(i)) stored = regs_q[i];
    end
    if (rd_idx == TOP_IDX) begin
      if (idx_ctx_e'(rd_sp_ctx) == CTX_STACK) fresh = sp_we ? sp_val : sp_q;
      else                                    fresh = '0;
    end else if (norm_we && norm_idx == rd_idx) begin
      fresh = norm_val;
    end else if (lnk_we && rd_idx == LNK_IDX) begin
      fresh = lnk_val;
    end else begin
      fresh = stored;
    end
    shaped = rd_narrow ? {{(XLEN-NARROW){1'b0}}, fresh[NARROW-1:0]} : fresh;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= shaped;
  end

  // R2: zero-context top index reads as zero
  p_zero_read_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_idx == TOP_IDX && !rd_sp_ctx) |=> (rd_q == '0));

  // R6: narrow reads carry no upper bits
  p_narrow_read_r6: assert property (@(posedge clk) disable iff (rst)
    rd_narrow |=> (rd_q[XLEN-1:NARROW] == '0));

  // R4: stack-context read with no pending write returns the stored pointer
  p_sp_read_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_idx == TOP_IDX && rd_sp_ctx && !rd_narrow && !sp_we) |=> (rd_q == $past(sp_q)));
endmodule

// File: rtl/gpr_bank_alias.sv
module gpr_bank_alias #(
  parameter int unsigned XLEN      = gpr_pkg::DEF_XLEN,
  parameter int unsigned NARROW    = gpr_pkg::DEF_NARROW,
  parameter int unsigned NREG      = gpr_pkg::DEF_NREG,
  parameter int unsigned LINK_STEP = gpr_pkg::DEF_STEP,
  localparam int unsigned IDX_W    = $clog2(NREG + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [XLEN-1:0]  wr_data,
  input  logic             wr_narrow,
  input  logic             wr_sp_ctx,
  input  logic             lnk_en,
  input  logic [XLEN-1:0]  lnk_pc,
  input  logic [IDX_W-1:0] rda_idx,
  input  logic             rda_narrow,
  input  logic             rda_sp_ctx,
  input  logic [IDX_W-1:0] rdb_idx,
  input  logic             rdb_narrow,
  input  logic             rdb_sp_ctx,
  output logic [XLEN-1:0]  rda_data,
  output logic [XLEN-1:0]  rdb_data
);
  localparam int unsigned NRD = 2;
  localparam logic [IDX_W-1:0] LNK_IDX = IDX_W'(NREG - 1);

  logic                      norm_we, lnk_we, sp_we;
  logic [IDX_W-1:0]          norm_idx;
  logic [XLEN-1:0]           norm_val, lnk_val, sp_val, sp_q;
  logic [NREG-1:0][XLEN-1:0] regs_q;

  logic [NRD-1:0][IDX_W-1:0] p_idx;
  logic [NRD-1:0]            p_nar, p_ctx;
  logic [NRD-1:0][XLEN-1:0]  p_dat;

  assign p_idx = {rdb_idx, rda_idx};
  assign p_nar = {rdb_narrow, rda_narrow};
  assign p_ctx = {rdb_sp_ctx, rda_sp_ctx};
  assign rda_data = p_dat[0];
  assign rdb_data = p_dat[1];

  gpr_write_ctrl #(.XLEN(XLEN), .NARROW(NARROW), .NREG(NREG), .LINK_STEP(LINK_STEP)) u_wctl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .wr_narrow(wr_narrow), .wr_sp_ctx(wr_sp_ctx), .lnk_en(lnk_en), .lnk_pc(lnk_pc),
    .norm_we(norm_we), .norm_idx(norm_idx), .norm_val(norm_val),
    .lnk_we(lnk_we), .lnk_val(lnk_val), .sp_we(sp_we), .sp_val(sp_val)
  );

  gpr_storage #(.XLEN(XLEN), .NREG(NREG)) u_store (
    .clk(clk), .rst(rst), .norm_we(norm_we), .norm_idx(norm_idx), .norm_val(norm_val),
    .lnk_we(lnk_we), .lnk_val(lnk_val), .sp_we(sp_we), .sp_val(sp_val),
    .regs_q(regs_q), .sp_q(sp_q)
  );

  genvar p;
  generate
    for (p = 0; p < NRD; p++) begin : g_rd
      gpr_read_port #(.XLEN(XLEN), .NARROW(NARROW), .NREG(NREG)) u_port (
        .clk(clk), .rst(rst), .rd_idx(p_idx[p]), .rd_narrow(p_nar[p]), .rd_sp_ctx(p_ctx[p]),
        .regs_q(regs_q), .sp_q(sp_q), .norm_we(norm_we), .norm_idx(norm_idx),
        .norm_val(norm_val), .lnk_we(lnk_we), .lnk_val(lnk_val),
        .sp_we(sp_we), .sp_val(sp_val), .rd_q(p_dat[p])
      );
    end
  endgenerate

  // R5: a narrow write read back at full width in the same cycle has clear upper bits
  p_zext_write_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_narrow && wr_idx < IDX_W'(NREG) && rda_idx == wr_idx && !rda_narrow)
    |=> (rda_data[XLEN-1:NARROW] == '0));

  // R8: colliding writes to register 30 forward the normal write data
  p_link_loses_r8: assert property (@(posedge clk) disable iff (rst)
    (lnk_en && wr_en && !wr_narrow && wr_idx == LNK_IDX && rda_idx == LNK_IDX && !rda_narrow)
    |=> (rda_data == $past(wr_data)));
endmodule

// File: tb/test_gpr_bank_alias.sv
module test_gpr_bank_alias;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 0, wr_narrow = 0, wr_sp_ctx = 0, lnk_en = 0;
  logic [4:0]  wr_idx = 0, rda_idx = 0, rdb_idx = 0;
  logic [63:0] wr_data = 0, lnk_pc = 0;
  logic        rda_narrow = 0, rda_sp_ctx = 0, rdb_narrow = 0, rdb_sp_ctx = 0;
  logic [63:0] rda_data, rdb_data;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [63:0] mdl [31];
  logic [63:0] msp;

  always #5ns clk = ~clk;

  gpr_bank_alias i_gpr_bank_alias (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .wr_narrow(wr_narrow), .wr_sp_ctx(wr_sp_ctx), .lnk_en(lnk_en), .lnk_pc(lnk_pc),
    .rda_idx(rda_idx), .rda_narrow(rda_narrow), .rda_sp_ctx(rda_sp_ctx),
    .rdb_idx(rdb_idx), .rdb_narrow(rdb_narrow), .rdb_sp_ctx(rdb_sp_ctx),
    .rda_data(rda_data), .rdb_data(rdb_data)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] mread(input logic [4:0] i, input logic n, input logic c);
    logic [63:0] v;
    if (i == 5'd31) v = c ? msp : 64'd0;
    else            v = mdl[i];
    return n ? {32'd0, v[31:0]} : v;
  endfunction

  task automatic cyc(input string tag,
                     input logic we, input logic [4:0] wi, input logic [63:0] wd,
                     input logic wn, input logic wc, input logic le, input logic [63:0] lp,
                     input logic [4:0] ai, input logic an, input logic ac,
                     input logic [4:0] bi, input logic bn, input logic bc);
    logic [63:0] v, ea, eb;
    wr_en = we; wr_idx = wi; wr_data = wd; wr_narrow = wn; wr_sp_ctx = wc;
    lnk_en = le; lnk_pc = lp;
    rda_idx = ai; rda_narrow = an; rda_sp_ctx = ac;
    rdb_idx = bi; rdb_narrow = bn; rdb_sp_ctx = bc;
    if (le) mdl[30] = lp + 64'd4;
    if (we) begin
      v = wn ? {32'd0, wd[31:0]} : wd;
      if (wi == 5'd31) begin
        if (wc) msp = v;
      end else begin
        mdl[wi] = v;
      end
    end
    ea = mread(ai, an, ac);
    eb = mread(bi, bn, bc);
    @(posedge clk); #1;
    check({tag, " portA"}, rda_data, ea);
    check({tag, " portB"}, rdb_data, eb);
  endtask

  task automatic rd2(input string tag, input logic [4:0] ai, input logic an, input logic ac,
                     input logic [4:0] bi, input logic bn, input logic bc);
    cyc(tag, 0, 0, 0, 0, 0, 0, 0, ai, an, ac, bi, bn, bc);
  endtask

  task automatic wr(input logic [4:0] wi, input logic [63:0] wd, input logic wn, input logic wc);
    cyc("write", 1, wi, wd, wn, wc, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #2ms;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 31; i++) mdl[i] = 64'd0;
    msp = 64'd0;
    rst = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check("R10 reset out A", rda_data, 64'd0);
    check("R10 reset out B", rdb_data, 64'd0);
    rst = 1'b0;

    // R1: write then read on both ports
    wr(5'd5, 64'hA5A5_0000_1234_5678, 0, 0);
    wr(5'd0, 64'h0123_4567_89AB_CDEF, 0, 0);
    rd2("R1 read back", 5'd5, 0, 0, 5'd0, 0, 0);

    // R9: same-cycle bypass, wide and narrow
    cyc("R9 bypass wide", 1, 5'd7, 64'hDEAD_BEEF_CAFE_F00D, 0, 0, 0, 0, 5'd7, 0, 0, 5'd7, 1, 0);
    wr(5'd8, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0);
    cyc("R9 bypass narrow", 1, 5'd8, 64'h1111_2222_3333_4444, 1, 0, 0, 0, 5'd8, 0, 0, 5'd8, 0, 1);

    // R4: stack pointer in stack context
    wr(5'd31, 64'h0000_7FFF_FFFF_F000, 0, 1);
    rd2("R4 sp read", 5'd31, 0, 1, 5'd30, 0, 0);

    // R2: zero context reads zero while sp is non-zero
    rd2("R2 zero read", 5'd31, 0, 0, 5'd31, 1, 0);

    // R3: zero-context write discarded; sp and registers unchanged
    wr(5'd31, 64'h5555_5555_5555_5555, 0, 0);
    rd2("R3 sp intact", 5'd31, 0, 1, 5'd5, 0, 0);
    rd2("R3 zero intact", 5'd31, 0, 0, 5'd7, 0, 0);

    // R5: narrow write clears upper bits
    wr(5'd12, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0);
    wr(5'd12, 64'h9876_5432_8000_0001, 1, 0);
    rd2("R5 zero extend", 5'd12, 0, 0, 5'd12, 0, 0);

    // R6: narrow read of full register
    rd2("R6 narrow read", 5'd0, 1, 0, 5'd31, 1, 1);

    // R7: link write
    cyc("R7 link", 0, 0, 0, 0, 0, 1, 64'h0000_0000_0040_1000, 5'd29, 0, 0, 5'd30, 0, 0);
    rd2("R7 link read", 5'd30, 0, 0, 5'd30, 1, 0);

    // R9: link bypass
    cyc("R9 link bypass", 0, 0, 0, 0, 0, 1, 64'hFFFF_FFFF_FFFF_FFFE, 5'd30, 0, 0, 5'd1, 0, 0);

    // R8: normal write beats link write to register 30
    cyc("R8 collision", 1, 5'd30, 64'h0BAD_F00D_0000_0042, 0, 0, 1, 64'h1000, 5'd30, 0, 0, 5'd30, 1, 0);
    rd2("R8 collision held", 5'd30, 0, 0, 5'd29, 0, 0);

    // R1: random mixed traffic against the model
    for (int k = 0; k < 400; k++) begin
      cyc("R1 random", $urandom_range(0, 3) != 0, 5'($urandom_range(0, 31)),
          {$urandom, $urandom}, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
          $urandom_range(0, 5) == 0, {$urandom, $urandom},
          5'($urandom_range(0, 31)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
          5'($urandom_range(0, 31)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    // R10: reset clears everything
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    for (int i = 0; i < 31; i++) mdl[i] = 64'd0;
    msp = 64'd0;
    check("R10 out cleared", rda_data, 64'd0);
    for (int i = 0; i < 31; i += 2) begin
      rd2("R10 cleared reg", 5'(i), 0, 0, 5'(i + 1), 0, 1);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule